// File: doc/BRIEF.md
# Pipelined Maximum-Priority Selector

This block picks the winner from a vector of per-channel priorities. It is used after the per-stream priority logic of a link scheduler. Each clock, the caller can present a full vector of `NUM_CH` priorities together with a start strobe. After a fixed number of cycles, equal to log2 of `NUM_CH`, the block returns the index of the entry with the largest priority.

The selection runs through a balanced binary tree of pairwise comparators with one register level per tree level. Each comparator passes on the larger priority and carries its channel index with it. A priority of zero means the channel is not competing. When no channel competes, the block still produces its completion pulse, but it keeps the valid flag low.

Because every tree level is registered and no stage stalls, a new vector can be accepted on every cycle. Results come out in the order the vectors were presented.

Top module: `prio_max_sel`

## Requirements
- R1: Channel i's priority is the unsigned field `prio_i[i*PRIO_W +: PRIO_W]`. When a result is delivered, `win_id_o` is the index of a channel with the largest priority in the sampled vector.
- R2: When several channels share the largest priority, the lowest index among them is returned.
- R3: A channel with priority zero never wins while any other channel has a nonzero priority.
- R4: If every priority in the sampled vector is zero, `done_o` still pulses, `win_valid_o` stays low and `win_id_o` is 0. For any nonzero maximum, `win_valid_o` is high.
- R5: A vector is sampled on a rising edge where `start_i` is high. Its result is present, with `done_o` high, in the cycle after the LEVELS-th rising edge, counting the sampling edge as the first. LEVELS is log2(`NUM_CH`). `done_o` is high for exactly one cycle per start.
- R6: Vectors may be started on consecutive cycles. Each produces its own result, in order of arrival, on consecutive cycles.
- R7: Changes on `prio_i` while `start_i` is low produce no `done_o` and no `win_valid_o`. `win_valid_o` is never high without `done_o`.
- R8: While `rst_n` is low, and directly after reset, `done_o` and `win_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sample the priority vector on this edge |
| prio_i | input | NUM_CH*PRIO_W | Packed priorities, channel i at bits i*PRIO_W upward |
| win_id_o | output | $clog2(NUM_CH) | Index of the winning channel |
| win_valid_o | output | 1 | Winner exists (maximum priority nonzero) |
| done_o | output | 1 | One-cycle pulse marking a delivered result |

## Verification
Each result is due LEVELS rising edges after its start, counting the sampling edge. For the default 32 channels, that is five edges. Every task drives its stimulus at a falling edge, counts the same number of rising edges, and samples at the following falling edge. It also confirms that `done_o` is low one cycle before and one cycle after the pulse. In the back-to-back burst, the bench checks at each falling edge the vector started LEVELS falling edges earlier, so every output is compared in the one cycle it is due.

// File: rtl/prio_max_sel.sv
module prio_max_sel #(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic [$clog2(NUM_CH)-1:0] win_id_o,
  output logic                     win_valid_o,
  output logic                     done_o
);
  localparam int ID_W   = $clog2(NUM_CH);
  localparam int LEVELS = ID_W;
  localparam int NODES  = NUM_CH - 1;

  logic [PRIO_W-1:0] leaf_pr [NUM_CH];
  logic [PRIO_W-1:0] node_pr [NODES];
  logic [ID_W-1:0]   node_id [NODES];
  logic [LEVELS-1:0] tag_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_leaf
    assign leaf_pr[i] = prio_i[i*PRIO_W +: PRIO_W];
  end

  // heap-ordered tree: node k has children 2k+1 (lower indices) and 2k+2
  for (genvar k = 0; k < NODES; k++) begin : g_node
    localparam int LC = 2*k + 1;
    localparam int RC = 2*k + 2;
    logic [PRIO_W-1:0] a_pr, b_pr;
    logic [ID_W-1:0]   a_id, b_id;

    if (LC >= NODES) begin : g_from_leaf
      assign a_pr = leaf_pr[LC-NODES];
      assign a_id = ID_W'(LC-NODES);
      assign b_pr = leaf_pr[RC-NODES];
      assign b_id = ID_W'(RC-NODES);
    end else begin : g_from_node
      assign a_pr = node_pr[LC];
      assign a_id = node_id[LC];
      assign b_pr = node_pr[RC];
      assign b_id = node_id[RC];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        node_pr[k] <= '0;
        node_id[k] <= '0;
      end else if (b_pr > a_pr) begin
        node_pr[k] <= b_pr;
        node_id[k] <= b_id;
      end else begin
        node_pr[k] <= a_pr;
        node_id[k] <= a_id;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= {tag_q[LEVELS-2:0], start_i};
  end

  assign done_o      = tag_q[LEVELS-1];
  assign win_id_o    = node_id[0];
  assign win_valid_o = done_o && (node_pr[0] != '0);
endmodule

// File: rtl/prio_max_sel_chk.sv
module prio_max_sel_chk #(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start_i,
  input logic [NUM_CH*PRIO_W-1:0]  prio_i,
  input logic [$clog2(NUM_CH)-1:0] win_id_o,
  input logic                      win_valid_o,
  input logic                      done_o
);
  localparam int LEVELS = $clog2(NUM_CH);

  function automatic int scan_id(input logic [NUM_CH*PRIO_W-1:0] v);
    int best = 0;
    for (int i = 1; i < NUM_CH; i++)
      if (v[i*PRIO_W +: PRIO_W] > v[best*PRIO_W +: PRIO_W]) best = i;
    return best;
  endfunction

  function automatic logic any_set(input logic [NUM_CH*PRIO_W-1:0] v);
    return v != '0;
  endfunction

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == $past(start_i, LEVELS));

  p_winner_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> int'(win_id_o) == scan_id($past(prio_i, LEVELS)));

  p_valid_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> win_valid_o == any_set($past(prio_i, LEVELS)));

  p_valid_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> done_o);

  p_empty_id_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !win_valid_o) |-> win_id_o == '0);
endmodule

bind prio_max_sel prio_max_sel_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .prio_i(prio_i),
  .win_id_o(win_id_o), .win_valid_o(win_valid_o), .done_o(done_o));

// File: tb/prio_max_sel_tb.sv
`timescale 1ns/1ps
module prio_max_sel_tb;
  localparam int NUM_CH = 32;
  localparam int PRIO_W = 12;
  localparam int ID_W   = $clog2(NUM_CH);
  localparam int LEVELS = ID_W;
  localparam int BURST  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NUM_CH*PRIO_W-1:0] prio_i = '0;
  logic [ID_W-1:0] win_id_o;
  logic win_valid_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prio_max_sel #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prio_i(prio_i),
    .win_id_o(win_id_o), .win_valid_o(win_valid_o), .done_o(done_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_id(input logic [NUM_CH*PRIO_W-1:0] v);
    int best = 0;
    for (int i = 0; i < NUM_CH; i++)
      if (v[i*PRIO_W +: PRIO_W] > v[best*PRIO_W +: PRIO_W]) best = i;
    return best;
  endfunction

  function automatic logic [NUM_CH*PRIO_W-1:0] setp(
      input logic [NUM_CH*PRIO_W-1:0] v, input int ch, input int p);
    v[ch*PRIO_W +: PRIO_W] = PRIO_W'(p);
    return v;
  endfunction

  // one start, result sampled LEVELS edges later, pulse width checked
  task automatic run_one(input logic [NUM_CH*PRIO_W-1:0] v, input string req);
    @(negedge clk);
    start_i = 1'b1; prio_i = v;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; prio_i = '0;
    repeat (LEVELS-2) @(posedge clk);
    @(negedge clk);
    check({req, " done low before due"}, int'(done_o), 0);
    @(negedge clk);
    check({req, " done"}, int'(done_o), 1);
    check({req, " id"}, int'(win_id_o), exp_id(v));
    check({req, " valid"}, int'(win_valid_o), int'(v != '0));
    @(negedge clk);
    check({req, " R5 pulse width"}, int'(done_o), 0);
  endtask

  task automatic t_reset;
    check("R8 done in reset", int'(done_o), 0);
    check("R8 valid in reset", int'(win_valid_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 done after reset", int'(done_o), 0);
  endtask

  task automatic t_basic;
    logic [NUM_CH*PRIO_W-1:0] v = '0;
    v = setp(v, 7, 300); v = setp(v, 20, 299); v = setp(v, 3, 12);
    run_one(v, "R1 single max");
    v = '0; v = setp(v, 31, 4095); v = setp(v, 0, 4094);
    run_one(v, "R1 top channel");
    v = '0; v = setp(v, 0, 1);
    run_one(v, "R1 channel zero");
  endtask

  task automatic t_ties;
    logic [NUM_CH*PRIO_W-1:0] v = '0;
    v = setp(v, 9, 50); v = setp(v, 25, 50); v = setp(v, 17, 50);
    run_one(v, "R2 tie lowest");
    v = '0;
    for (int i = 0; i < NUM_CH; i++) v = setp(v, i, 77);
    run_one(v, "R2 all equal");
  endtask

  task automatic t_zero;
    logic [NUM_CH*PRIO_W-1:0] v = '0;
    v = setp(v, 30, 1);
    run_one(v, "R3 only nonzero wins");
    run_one('0, "R4 empty vector");
    check("R4 empty id zero", int'(win_id_o), 0);
  endtask

  task automatic t_burst;
    logic [NUM_CH*PRIO_W-1:0] vs [BURST];
    for (int b = 0; b < BURST; b++) begin
      vs[b] = '0;
      vs[b] = setp(vs[b], (b*5) % NUM_CH, 100 + b);
      vs[b] = setp(vs[b], (b*11 + 3) % NUM_CH, 100 + b);
    end
    vs[3] = '0;
    for (int n = 0; n <= BURST + LEVELS; n++) begin
      @(negedge clk);
      if (n - LEVELS >= 0 && n - LEVELS < BURST) begin
        check("R6 burst done", int'(done_o), 1);
        check("R6 burst id", int'(win_id_o), exp_id(vs[n-LEVELS]));
        check("R6 burst valid", int'(win_valid_o), int'(vs[n-LEVELS] != '0));
      end else begin
        check("R6 no stray done", int'(done_o), 0);
      end
      start_i = (n < BURST);
      prio_i  = (n < BURST) ? vs[n] : '0;
    end
  endtask

  task automatic t_idle;
    for (int n = 0; n < 3*LEVELS; n++) begin
      @(negedge clk);
      check("R7 idle done", int'(done_o), 0);
      check("R7 idle valid", int'(win_valid_o), 0);
      prio_i = setp('0, n % NUM_CH, 900 + n);
    end
    prio_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_ties();
    t_zero();
    t_burst();
    t_idle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule